// File: doc/BRIEF.md
# Sprite Attribute Memory with Deferred Row Corruption

This block holds the sprite attribute table of a video controller: 256 bytes arranged as 32 rows of 8 bytes, which covers 64 entries of 4 bytes each. The CPU loads a byte pointer and then writes bytes one after another. Each write advances the pointer. A combinational read port always shows the byte under the pointer.

The block also models a latent hardware fault. The controller's rendering-enable request reaches the rendering logic after a fixed pipeline delay. If rendering is switched off while a rendering scanline is in progress, and the switch-off takes effect inside one of two dot windows, the block records one doomed row and raises a debug flag. The fault then waits, across any number of frames and across reset. On the first dot where rendering runs again, the block overwrites the doomed row with a byte-by-byte copy of row 0. Any bytes the CPU wrote to that row in the meantime are lost.

The dot and scanline counters are inputs. Scanline 261 is the pre-render line, so the vertical-blank re-enable case fires on scanline 261, dot 0.

Top module: `sprite_mem_fault`

## Requirements
- R1: A change of `render_req_i` becomes the effective rendering enable 3 clock cycles (dots) later. Rendering counts as active when the effective enable is 1 and `line_i` is below 240 or equal to 261.
- R2: An effective 1-to-0 transition of the enable on a rendering line, landing on dot 1 to 64, arms the fault. The doomed row is floor(dot/2) modulo 32.
- R3: An effective disable landing on dot 257 to 320 of a rendering line also arms the fault. The dots are taken in groups of 8, and group g covers rows 4g to 4g+3. Within a group, rows 4g, 4g+1 and 4g+2 each own one dot. Row 4g+3 owns the last five dots.
- R4: An effective disable on any other dot, or on a line that is not a rendering line, leaves `fault_pending_o` low.
- R5: When a fault is pending, the first dot with rendering active fires it. `fault_pending_o` is low from the next dot on. Over the following 8 dots, byte k of row 0 is copied to byte k of the doomed row, one byte per dot, in increasing k. Byte address = row*8 + byte.
- R6: An armed fault stays pending for any number of dots in which rendering is not active, and through assertion of `rst_n`.
- R7: CPU writes made to the doomed row while the fault is pending do not clear it. When the fault fires, the copy replaces them.
- R8: During the 8-dot copy, a CPU write whose pointer lies in the doomed row is dropped.
- R9: A fault armed after an earlier one has fired records its own row. The next firing copies row 0 over only that row.
- R10: `ptr_wr_i` loads the pointer from `ptr_data_i`. Each `wr_en_i` stores `wr_data_i` at the pointer and then advances the pointer by 1 modulo 256. `rd_data_o` shows the byte at the pointer.
- R11: Reset sets the pointer to 0 and the effective enable to 0. At power-up no fault is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low controller reset |
| dot_i | input | 9 | Current dot within the scanline (0..340) |
| line_i | input | 9 | Current scanline (0..261, 261 = pre-render) |
| render_req_i | input | 1 | Rendering-enable request as written by the CPU |
| ptr_wr_i | input | 1 | Load the byte pointer |
| ptr_data_i | input | 8 | New pointer value |
| wr_en_i | input | 1 | Write one byte at the pointer |
| wr_data_i | input | 8 | Byte to write |
| rd_data_o | output | 8 | Byte at the pointer |
| fault_pending_o | output | 1 | A row corruption is armed and waiting |

## Verification
The hardest state to reach is a fault armed on one exact dot. The disable request must be placed three dots ahead of the target dot, in a stream of dots that does not break, so the stimulus walks absolute dot positions across line boundaries. For every table vector, a fresh known pattern is written into memory. The CPU then overwrites the doomed row during vertical blank. Rendering is re-enabled before the pre-render line, so the firing dot, the 8-dot copy and a CPU write collision can all be placed on exact dots. Persistence is checked by crossing a frame with rendering off and pulsing reset while the fault is armed.

// File: rtl/sprite_fault_pkg.sv
`timescale 1ns/1ps
package sprite_fault_pkg;

   // Which arming window an effective disable landed in
   typedef enum logic [1:0] {
      WIN_NONE  = 2'd0,
      WIN_EARLY = 2'd1,
      WIN_LATE  = 2'd2
   } win_e;

   // Late window layout: rows handled in groups, each group spanning a fixed dot count
   localparam int unsigned LATE_GROUP_ROWS = 4;
   localparam int unsigned LATE_GROUP_DOTS = 8;

endpackage

// File: rtl/sprite_en_pipe.sv
`timescale 1ns/1ps
module sprite_en_pipe #(
   parameter int unsigned DELAY = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   output logic en_o,
   output logic fall_o
);

   if (DELAY < 1) begin : g_bad_delay
      $error("sprite_en_pipe: DELAY must be at least 1");
   end

   logic [DELAY-1:0] st_q;
   logic             prev_q;

   if (DELAY == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) st_q <= '0;
         else        st_q <= req_i;
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) st_q <= '0;
         else        st_q <= {st_q[DELAY-2:0], req_i};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= st_q[DELAY-1];
   end

   assign en_o   = st_q[DELAY-1];
   assign fall_o = prev_q & ~st_q[DELAY-1];

   // Cycles since reset, saturating at DELAY, so the delay check never looks before reset
   localparam int unsigned WW = $clog2(DELAY + 1);
   logic [WW-1:0] warm_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       warm_q <= '0;
      else if (warm_q != WW'(DELAY))    warm_q <= warm_q + WW'(1);
   end

   a_r1_delay: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q == WW'(DELAY)) |-> (en_o == $past(req_i, DELAY)));

endmodule

// File: rtl/sprite_fault_arm.sv
`timescale 1ns/1ps
module sprite_fault_arm
   import sprite_fault_pkg::*;
#(
   parameter int unsigned ROWS     = 32,
   parameter int unsigned DOT_W    = 9,
   parameter int unsigned EARLY_LO = 1,
   parameter int unsigned EARLY_HI = 64,
   parameter int unsigned LATE_LO  = 257,
   parameter int unsigned LATE_HI  = 320,
   localparam int unsigned RW      = $clog2(ROWS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fall_i,
   input  logic             rend_line_i,
   input  logic [DOT_W-1:0] dot_i,
   input  logic             fire_i,
   output logic             pend_o,
   output logic [RW-1:0]    row_o
);

   if ((EARLY_HI - EARLY_LO + 1) != 2 * ROWS) begin : g_bad_early
      $error("sprite_fault_arm: early window must give every row two dots");
   end
   if ((LATE_HI - LATE_LO + 1) != (ROWS / LATE_GROUP_ROWS) * LATE_GROUP_DOTS
       || (ROWS % LATE_GROUP_ROWS) != 0) begin : g_bad_late
      $error("sprite_fault_arm: late window size does not match the row groups");
   end

   localparam logic [DOT_W-1:0] E_LO = DOT_W'(EARLY_LO);
   localparam logic [DOT_W-1:0] E_HI = DOT_W'(EARLY_HI);
   localparam logic [DOT_W-1:0] L_LO = DOT_W'(LATE_LO);
   localparam logic [DOT_W-1:0] L_HI = DOT_W'(LATE_HI);
   localparam logic [2:0]       LAST_SINGLE = 3'(LATE_GROUP_ROWS - 2);

   win_e             win;
   logic [DOT_W-1:0] off;
   logic [2:0]       sub;
   logic [RW-1:0]    row_early;
   logic [RW-1:0]    row_late;
   logic [RW-1:0]    row_new;
   logic             arm;

   always_comb begin
      if (dot_i >= E_LO && dot_i <= E_HI)      win = WIN_EARLY;
      else if (dot_i >= L_LO && dot_i <= L_HI) win = WIN_LATE;
      else                                     win = WIN_NONE;
   end

   always_comb begin
      off       = dot_i - L_LO;
      sub       = (off[2:0] > LAST_SINGLE) ? 3'(LATE_GROUP_ROWS - 1) : off[2:0];
      row_early = RW'(dot_i >> 1);
      row_late  = RW'((off / DOT_W'(LATE_GROUP_DOTS)) * DOT_W'(LATE_GROUP_ROWS) + DOT_W'(sub));
      row_new   = (win == WIN_LATE) ? row_late : row_early;
      arm       = fall_i && rend_line_i && (win != WIN_NONE);
   end

   // Fault state survives controller reset: no reset term, power-up value only
   logic          pend_q = 1'b0;
   logic [RW-1:0] row_q  = '0;

   always_ff @(posedge clk) begin
      if (arm) begin
         pend_q <= 1'b1;
         row_q  <= row_new;
      end else if (fire_i) begin
         pend_q <= 1'b0;
      end
   end

   assign pend_o = pend_q;
   assign row_o  = row_q;

   a_r4_off_line: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_i && !rend_line_i && !fire_i) |=> (pend_o == $past(pend_o)) && (row_o == $past(row_o)));

   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!fall_i && !fire_i) |=> (pend_o == $past(pend_o)) && (row_o == $past(row_o)));

   a_r5_fire_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_i && !fall_i) |=> !pend_o);

endmodule

// File: rtl/sprite_row_copy.sv
`timescale 1ns/1ps
module sprite_row_copy #(
   parameter int unsigned ROWS      = 32,
   parameter int unsigned ROW_BYTES = 8,
   localparam int unsigned RW       = $clog2(ROWS),
   localparam int unsigned BW       = $clog2(ROW_BYTES),
   localparam int unsigned AW       = RW + BW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [RW-1:0] row_i,
   output logic          busy_o,
   output logic [RW-1:0] row_o,
   output logic [AW-1:0] src_o,
   output logic [AW-1:0] dst_o
);

   if ((1 << BW) != ROW_BYTES || (1 << RW) != ROWS) begin : g_bad_shape
      $error("sprite_row_copy: ROWS and ROW_BYTES must be powers of two");
   end

   localparam logic [BW-1:0] LAST = BW'(ROW_BYTES - 1);

   // Copy engine is part of the fault state and also ignores controller reset
   logic          busy_q = 1'b0;
   logic [BW-1:0] cnt_q  = '0;
   logic [RW-1:0] row_q  = '0;

   always_ff @(posedge clk) begin
      if (start_i && !busy_q) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
         row_q  <= row_i;
      end else if (busy_q) begin
         if (cnt_q == LAST) busy_q <= 1'b0;
         cnt_q <= cnt_q + BW'(1);
      end
   end

   assign busy_o = busy_q;
   assign row_o  = row_q;
   assign src_o  = {RW'(0), cnt_q};
   assign dst_o  = {row_q, cnt_q};

   a_r5_runs_on: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cnt_q != LAST) |=> busy_q && (cnt_q == $past(cnt_q) + BW'(1)));

   a_r5_stops: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cnt_q == LAST) |=> !busy_q);

   a_r5_starts_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> (cnt_q == '0));

endmodule

// File: rtl/sprite_attr_ram.sv
`timescale 1ns/1ps
module sprite_attr_ram #(
   parameter int unsigned DEPTH  = 256,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              a_we,
   input  logic [AW-1:0]     a_addr,
   input  logic [DATA_W-1:0] a_data,
   input  logic              b_we,
   input  logic [AW-1:0]     b_addr,
   input  logic [DATA_W-1:0] b_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic [AW-1:0]     src_addr,
   output logic [DATA_W-1:0] src_data
);

   logic [DATA_W-1:0] mem_q [DEPTH];

   // Port b (row copy) is written after port a; the caller keeps them apart
   always_ff @(posedge clk) begin
      if (a_we) mem_q[a_addr] <= a_data;
      if (b_we) mem_q[b_addr] <= b_data;
   end

   assign rd_data  = mem_q[rd_addr];
   assign src_data = mem_q[src_addr];

endmodule

// File: rtl/sprite_mem_fault.sv
`timescale 1ns/1ps
module sprite_mem_fault #(
   parameter int unsigned ROWS      = 32,
   parameter int unsigned ROW_BYTES = 8,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned DOT_W     = 9,
   parameter int unsigned LINE_W    = 9,
   parameter int unsigned EN_DELAY  = 3,
   parameter int unsigned VIS_LINES = 240,
   parameter int unsigned PRE_LINE  = 261,
   parameter int unsigned EARLY_LO  = 1,
   parameter int unsigned EARLY_HI  = 64,
   parameter int unsigned LATE_LO   = 257,
   parameter int unsigned LATE_HI   = 320,
   localparam int unsigned DEPTH    = ROWS * ROW_BYTES,
   localparam int unsigned AW       = $clog2(DEPTH),
   localparam int unsigned RW       = $clog2(ROWS),
   localparam int unsigned BW       = $clog2(ROW_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DOT_W-1:0]  dot_i,
   input  logic [LINE_W-1:0] line_i,
   input  logic              render_req_i,
   input  logic              ptr_wr_i,
   input  logic [AW-1:0]     ptr_data_i,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              fault_pending_o
);

   if (PRE_LINE < VIS_LINES || PRE_LINE >= (1 << LINE_W)) begin : g_bad_lines
      $error("sprite_mem_fault: PRE_LINE must follow the visible lines and fit LINE_W");
   end

   localparam logic [LINE_W-1:0] VIS_L = LINE_W'(VIS_LINES);
   localparam logic [LINE_W-1:0] PRE_L = LINE_W'(PRE_LINE);

   logic              en_eff, en_fall;
   logic              rend_line, active, fire;
   logic              pend;
   logic [RW-1:0]     pend_row;
   logic              busy;
   logic [RW-1:0]     copy_row;
   logic [AW-1:0]     copy_src, copy_dst;
   logic [DATA_W-1:0] src_byte;
   logic [AW-1:0]     ptr_q;
   logic              cpu_in_copy_row, cpu_we;

   sprite_en_pipe #(.DELAY(EN_DELAY)) u_pipe (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (render_req_i),
      .en_o   (en_eff),
      .fall_o (en_fall)
   );

   assign rend_line = (line_i < VIS_L) || (line_i == PRE_L);
   assign active    = en_eff && rend_line;
   assign fire      = pend && active && !busy;

   sprite_fault_arm #(
      .ROWS     (ROWS),
      .DOT_W    (DOT_W),
      .EARLY_LO (EARLY_LO),
      .EARLY_HI (EARLY_HI),
      .LATE_LO  (LATE_LO),
      .LATE_HI  (LATE_HI)
   ) u_arm (
      .clk         (clk),
      .rst_n       (rst_n),
      .fall_i      (en_fall),
      .rend_line_i (rend_line),
      .dot_i       (dot_i),
      .fire_i      (fire),
      .pend_o      (pend),
      .row_o       (pend_row)
   );

   sprite_row_copy #(.ROWS(ROWS), .ROW_BYTES(ROW_BYTES)) u_copy (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (fire),
      .row_i   (pend_row),
      .busy_o  (busy),
      .row_o   (copy_row),
      .src_o   (copy_src),
      .dst_o   (copy_dst)
   );

   // Byte pointer: a load wins over the post-write increment
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ptr_q <= '0;
      else if (ptr_wr_i) ptr_q <= ptr_data_i;
      else if (wr_en_i)  ptr_q <= ptr_q + AW'(1);
   end

   assign cpu_in_copy_row = busy && (ptr_q[AW-1:BW] == copy_row);
   assign cpu_we          = wr_en_i && !cpu_in_copy_row;

   sprite_attr_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ram (
      .clk      (clk),
      .a_we     (cpu_we),
      .a_addr   (ptr_q),
      .a_data   (wr_data_i),
      .b_we     (busy),
      .b_addr   (copy_dst),
      .b_data   (src_byte),
      .rd_addr  (ptr_q),
      .rd_data  (rd_data_o),
      .src_addr (copy_src),
      .src_data (src_byte)
   );

   assign fault_pending_o = pend;

   a_r8_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && busy && ptr_q[AW-1:BW] == copy_row && ptr_q != copy_dst)
      |=> u_ram.mem_q[$past(ptr_q)] == $past(u_ram.mem_q[ptr_q]));

   a_r5_copy_byte: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> u_ram.mem_q[$past(copy_dst)] == $past(u_ram.mem_q[copy_src]));

   a_r10_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !ptr_wr_i) |=> ptr_q == $past(ptr_q) + AW'(1));

   a_r7_fire_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(active) && $past(pend));

endmodule

// File: tb/sprite_mem_fault_test.sv
`timescale 1ns/1ps
module sprite_mem_fault_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [8:0] dot_i = '0;
   logic [8:0] line_i = 9'd250;
   logic       render_req_i = 1'b0;
   logic       ptr_wr_i = 1'b0;
   logic [7:0] ptr_data_i = '0;
   logic       wr_en_i = 1'b0;
   logic [7:0] wr_data_i = '0;
   logic [7:0] rd_data_o;
   logic       fault_pending_o;

   int  nchk = 0;
   int  nfail = 0;
   logic req_hold = 1'b0;

   always #2 clk = ~clk;

   sprite_mem_fault uut (
      .clk             (clk),
      .rst_n           (rst_n),
      .dot_i           (dot_i),
      .line_i          (line_i),
      .render_req_i    (render_req_i),
      .ptr_wr_i        (ptr_wr_i),
      .ptr_data_i      (ptr_data_i),
      .wr_en_i         (wr_en_i),
      .wr_data_i       (wr_data_i),
      .rd_data_o       (rd_data_o),
      .fault_pending_o (fault_pending_o)
   );

   localparam int LPD = 341;

   // {arm expected, row, dot}
   localparam int NVEC = 20;
   localparam logic [15:0] VEC [NVEC] = '{
      {1'b1, 5'd0,  10'd1},   {1'b1, 5'd1,  10'd2},   {1'b1, 5'd1,  10'd3},
      {1'b1, 5'd20, 10'd40},  {1'b1, 5'd31, 10'd63},  {1'b1, 5'd0,  10'd64},
      {1'b1, 5'd0,  10'd257}, {1'b1, 5'd1,  10'd258}, {1'b1, 5'd2,  10'd259},
      {1'b1, 5'd3,  10'd260}, {1'b1, 5'd3,  10'd264}, {1'b1, 5'd4,  10'd265},
      {1'b1, 5'd7,  10'd268}, {1'b1, 5'd23, 10'd300}, {1'b1, 5'd31, 10'd320},
      {1'b0, 5'd0,  10'd0},   {1'b0, 5'd0,  10'd65},  {1'b0, 5'd0,  10'd256},
      {1'b0, 5'd0,  10'd321}, {1'b0, 5'd0,  10'd340}
   };

   function automatic int pat(input int a);
      return (a * 37 + 11) & 255;
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input int l, input int d, input logic req,
                       input logic pw, input int pd, input logic we, input int wd);
      @(negedge clk);
      line_i       = 9'(l);
      dot_i        = 9'(d);
      render_req_i = req;
      ptr_wr_i     = pw;
      ptr_data_i   = 8'(pd);
      wr_en_i      = we;
      wr_data_i    = 8'(wd);
      req_hold     = req;
   endtask

   task automatic idle();            step(250, 0, req_hold, 1'b0, 0, 1'b0, 0); endtask
   task automatic setptr(input int a); step(250, 0, req_hold, 1'b1, a, 1'b0, 0); endtask
   task automatic wrb(input int v);  step(250, 0, req_hold, 1'b0, 0, 1'b1, v); endtask

   task automatic walk(input int start, input int n, input int drop, input int wr_at, input int wv);
      for (int t = 0; t < n; t++)
         step((start + t) / LPD, (start + t) % LPD, (drop < 0) || (t < drop),
              1'b0, 0, (t == wr_at), wv);
   endtask

   task automatic rdchk(input string tag, input int a, input int exp);
      setptr(a);
      idle();
      check(tag, int'(rd_data_o), exp);
   endtask

   task automatic fill();
      setptr(0);
      for (int a = 0; a < 256; a++) wrb(pat(a));
   endtask

   task automatic enable_vb();
      walk(245 * LPD, 6, -1, -1, 0);
   endtask

   // Request drop 3 dots ahead so the effective disable lands on 'dot'
   task automatic arm_at(input int line, input int dot);
      walk(line * LPD + dot - 8, 10, 5, -1, 0);
   endtask

   // Fire on line 261 dot 0; wr_at indexes the second part, which starts at dot 2
   task automatic fire(input int wr_at, input int wv);
      walk(260 * LPD + 330, 13, -1, -1, 0);
      check("R5 pending low after firing dot", int'(fault_pending_o), 0);
      walk(261 * LPD + 2, 10, -1, wr_at, wv);
   endtask

   task automatic pulse_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) idle();
      rst_n = 1'b1;
   endtask

   task automatic do_vec(input int dot, input logic exp_arm, input int row);
      string tag;
      int    e;
      if (dot <= 64 && dot >= 1)        tag = $sformatf("R1/R2 dot %0d", dot);
      else if (dot >= 257 && dot <= 320) tag = $sformatf("R1/R3 dot %0d", dot);
      else                               tag = $sformatf("R4 dot %0d", dot);
      fill();
      enable_vb();
      arm_at(100, dot);
      check(tag, int'(fault_pending_o), int'(exp_arm));
      if (exp_arm) begin
         // R7: CPU overwrites the doomed row while the fault waits
         setptr(row * 8);
         for (int k = 0; k < 8; k++) wrb(8'hEE);
         check("R7 pending kept after writes", int'(fault_pending_o), 1);
         enable_vb();
         fire(-1, 0);
         for (int k = 0; k < 8; k++) begin
            e = (row == 0) ? 8'hEE : pat(k);
            rdchk($sformatf("R5 row %0d byte %0d", row, k), row * 8 + k, e);
         end
         rdchk("R5 neighbour row untouched", ((row + 1) % 32) * 8, pat(((row + 1) % 32) * 8));
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (4) idle();
      rst_n = 1'b1;
      idle();
      check("R11 no fault at power-up", int'(fault_pending_o), 0);

      // R11: pointer returns to 0 on reset
      setptr(5);
      pulse_reset();
      wrb(8'h99);
      rdchk("R11 pointer reset", 0, 8'h99);

      // R10: pointer increments and wraps
      setptr(255);
      wrb(8'h12);
      wrb(8'h34);
      rdchk("R10 byte at 255", 255, 8'h12);
      rdchk("R10 wrap to 0", 0, 8'h34);

      for (int i = 0; i < NVEC; i++)
         do_vec(int'(VEC[i][9:0]), VEC[i][15], int'(VEC[i][14:10]));

      // R4: disable on a vertical-blank line does not arm
      enable_vb();
      walk(245 * LPD + 22, 10, 5, -1, 0);
      check("R4 vblank disable", int'(fault_pending_o), 0);

      // R6: pending through a rendering-off pre-render line and a reset
      fill();
      enable_vb();
      arm_at(100, 20);
      check("R6 armed row 10", int'(fault_pending_o), 1);
      walk(261 * LPD, 21, 0, -1, 0);
      check("R6 kept while rendering off", int'(fault_pending_o), 1);
      pulse_reset();
      idle();
      check("R6 kept through reset", int'(fault_pending_o), 1);
      enable_vb();
      fire(-1, 0);
      rdchk("R6 row 10 byte 3 copied", 10 * 8 + 3, pat(3));

      // R8: write to the doomed row during the copy is dropped
      fill();
      enable_vb();
      arm_at(100, 40);
      setptr(20 * 8);
      enable_vb();
      fire(2, 8'hC3);
      rdchk("R8 blocked write", 20 * 8, pat(0));
      rdchk("R8 next byte copied", 20 * 8 + 1, pat(1));

      // R9: a new arm after a firing targets its own row
      fill();
      enable_vb();
      arm_at(100, 2);
      enable_vb();
      walk(260 * LPD + 330, 13, -1, -1, 0);
      walk(261 * LPD + 2, 301, 295, -1, 0);
      check("R9 re-armed on pre-render line", int'(fault_pending_o), 1);
      setptr(0);
      wrb(8'h77);
      enable_vb();
      fire(-1, 0);
      rdchk("R9 new row 23 gets row 0", 23 * 8, 8'h77);
      rdchk("R9 old row 1 keeps first copy", 8, pat(0));

      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

endmodule